// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines and presents one interrupt output to a processor. Each line latches a request on its rising edge into a pending register. A per-line mask holds a pending request back without discarding it. When the processor acknowledges, the controller picks the highest-priority unmasked pending line. Line 0 has the highest priority and line 7 the lowest. The picked line moves from the pending register to an in-service register, and the controller returns the vector base plus the line number. A line in service holds off every request of equal or lower priority until software retires it with an end-of-interrupt command.

Software reaches the block through a byte-wide bus with two ports: a command port and a data port. An ordered sequence of initialization words sets the vector base, the cascade setting and the processor mode. A fourth word is optional. After the sequence, a data-port write loads the mask, and command-port writes carry the two end-of-interrupt forms. The block only records the cascade setting and drives it out to neighbouring logic. A primary unit keeps a map of the lines that carry a secondary unit. A secondary unit keeps its own identity number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service register reads 0x00 and the interrupt output is low. The output stays low until an initialization sequence has completed, even for unmasked pending requests.
- R2: A command-port write with bit 4 set starts initialization, and its bit 0 says whether a fourth word follows. The next data write sets the vector base. The one after that sets the cascade setting: the line map on a primary unit (`link_mask`), or an identity in bits 2:0 on a secondary unit (`link_id`). The optional fourth word sets `proc_mode` from its bit 0, and `proc_mode` is 0 when no fourth word is given. After the sequence, data writes load the mask.
- R3: An acknowledge while `int_out` is high returns base plus the index of the lowest-numbered unmasked pending line. The vector appears on `vec_out` with `vec_valid` high for one cycle, in the cycle after the acknowledge.
- R4: Mask bit n set to 1 keeps line n off `int_out` and out of selection, while its request stays pending. Clearing the bit lets the request through. A data-port read returns the mask.
- R5: While a line is in service, pending requests of equal or lower priority (equal or higher index) do not raise `int_out`. A strictly higher-priority request does raise it.
- R6: An acknowledge sets the chosen line's in-service bit and clears its pending bit. A command-port read returns the in-service register, bit n for line n.
- R7: Command byte 0x20 clears the lowest-numbered set bit of the in-service register.
- R8: Command byte 0x60 plus n (n in bits 2:0) clears only in-service bit n and leaves every other bit unchanged.
- R9: A request is latched only on a rising edge of its input. A line held high after being acknowledged does not request again.
- R10: An acknowledge while `int_out` is low returns base plus 7 and changes neither the in-service nor the pending register.
- R11: Starting initialization clears the in-service and pending registers. `int_out` is low until the sequence ends.
- R12: Other command bytes (bit 4 clear, not an end-of-interrupt form) change neither the in-service register nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_port | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Command port: in-service register; data port: mask |
| secondary | input | 1 | High when this unit is a secondary in a cascade |
| irq_req | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt to the processor |
| int_ack | input | 1 | Acknowledge from the processor, one cycle |
| vec_out | output | 8 | Vector returned for the acknowledge |
| vec_valid | output | 1 | vec_out is valid, one cycle after int_ack |
| link_mask | output | 8 | Map of lines with a secondary unit (primary only) |
| link_id | output | 3 | Cascade identity (secondary only) |
| proc_mode | output | 1 | Processor mode bit from the fourth word |

## Verification
The assertions check the following on every cycle:
- `int_out` is never high before initialization has finished.
- `int_out` is never high unless some unmasked request is pending.
- `int_out` is never high while line 0 is in service.
- Each acknowledge yields exactly one vector pulse. An acknowledge that is taken adds exactly one in-service bit, and one that is not taken adds none.
- Each end-of-interrupt command removes the bit it names.
- Starting initialization empties the in-service register.

Only the bench scenarios can show the rest:
- which line wins among several, and the vector values;
- ordering in the initialization sequence, with and without the fourth word;
- masked requests surviving until they are unmasked;
- edge-only latching;
- commands that have no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);
  localparam int BYTEW = 8;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_BASE = 2'd1,
    ST_LINK = 2'd2,
    ST_MODE = 2'd3
  } cfg_state_t;

  // vector returned for line idx
  function automatic logic [BYTEW-1:0] line_vector(input logic [BYTEW-1:0] base,
                                                   input logic [IDXW-1:0] idx);
    return base + BYTEW'(idx);
  endfunction

  function automatic logic [LINES-1:0] line_bit(input logic [IDXW-1:0] idx);
    return LINES'(1) << idx;
  endfunction

  // command byte decoding
  function automatic logic is_init_cmd(input logic [BYTEW-1:0] d);
    return d[4];
  endfunction

  function automatic logic is_eoi_any(input logic [BYTEW-1:0] d);
    return d == 8'h20;
  endfunction

  function automatic logic is_eoi_one(input logic [BYTEW-1:0] d);
    return d[7:3] == 5'b01100;
  endfunction
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
#(
  parameter int N  = LINES,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         hit,
  output logic [W-1:0] idx
);
  // lower_any[i]: some bit below i is set
  logic [N-1:0] lower_any;
  logic [N-1:0] first;

  assign lower_any[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_chain
      assign lower_any[g] = lower_any[g-1] | vec[g-1];
    end
    for (g = 0; g < N; g++) begin : g_first
      assign first[g] = vec[g] & ~lower_any[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = W'(i);
    end
  end

  assign hit = |vec;
endmodule

// File: rtl/irqc_bus_regs.sv
module irqc_bus_regs
  import irqc_pkg::*;
#(
  parameter int N  = LINES,
  parameter int DW = BYTEW,
  localparam int W = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_port,
  input  logic [DW-1:0] bus_wdata,
  input  logic          secondary,
  output logic          ready,
  output logic [N-1:0]  mask,
  output logic [DW-1:0] base,
  output logic [N-1:0]  link_mask,
  output logic [2:0]    link_id,
  output logic          proc_mode,
  output logic          init_clr,
  output logic          eoi_any,
  output logic          eoi_one,
  output logic [W-1:0]  eoi_idx
);
  cfg_state_t state;
  logic       want_mode;
  logic       cmd_wr, dat_wr;

  assign cmd_wr   = bus_wr & ~bus_port;
  assign dat_wr   = bus_wr & bus_port;
  assign init_clr = cmd_wr & is_init_cmd(bus_wdata);
  assign eoi_any  = cmd_wr & (state == ST_RUN) & is_eoi_any(bus_wdata);
  assign eoi_one  = cmd_wr & (state == ST_RUN) & is_eoi_one(bus_wdata);
  assign eoi_idx  = bus_wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      ready     <= 1'b0;
      want_mode <= 1'b0;
      mask      <= '1;
      base      <= '0;
      link_mask <= '0;
      link_id   <= '0;
      proc_mode <= 1'b0;
    end else if (init_clr) begin
      state     <= ST_BASE;
      ready     <= 1'b0;
      want_mode <= bus_wdata[0];
    end else if (dat_wr) begin
      unique case (state)
        ST_BASE: begin
          base  <= bus_wdata;
          state <= ST_LINK;
        end
        ST_LINK: begin
          if (secondary) begin
            link_id   <= bus_wdata[2:0];
            link_mask <= '0;
          end else begin
            link_mask <= bus_wdata[N-1:0];
            link_id   <= '0;
          end
          if (want_mode) begin
            state <= ST_MODE;
          end else begin
            state     <= ST_RUN;
            proc_mode <= 1'b0;
            ready     <= 1'b1;
          end
        end
        ST_MODE: begin
          proc_mode <= bus_wdata[0];
          state     <= ST_RUN;
          ready     <= 1'b1;
        end
        default: mask <= bus_wdata[N-1:0];
      endcase
    end
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
#(
  parameter int N  = LINES,
  parameter int DW = BYTEW,
  localparam int W = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic [N-1:0]  mask,
  input  logic [DW-1:0] base,
  input  logic          ready,
  input  logic          init_clr,
  input  logic          eoi_any,
  input  logic          eoi_one,
  input  logic [W-1:0]  eoi_idx,
  input  logic          int_ack,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr,
  output logic          int_out,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid
);
  logic [N-1:0] prev_req, rise, pend;
  logic [N-1:0] irr_nxt, isr_nxt;
  logic         p_hit, s_hit, take;
  logic [W-1:0] p_idx, s_idx;

  assign rise = irq_req & ~prev_req;
  assign pend = irr & ~mask;

  irqc_prio_enc #(.N(N)) u_pend_enc (.vec(pend), .hit(p_hit), .idx(p_idx));
  irqc_prio_enc #(.N(N)) u_serv_enc (.vec(isr),  .hit(s_hit), .idx(s_idx));

  // only a strictly higher priority line may pass the in-service level
  assign int_out = ready & p_hit & (~s_hit | (p_idx < s_idx));
  assign take    = int_ack & int_out;

  always_comb begin
    isr_nxt = isr;
    if (eoi_any && s_hit) isr_nxt = isr_nxt & ~line_bit(s_idx);
    if (eoi_one)          isr_nxt = isr_nxt & ~line_bit(eoi_idx);
    if (take)             isr_nxt = isr_nxt | line_bit(p_idx);
    if (init_clr)         isr_nxt = '0;
  end

  always_comb begin
    irr_nxt = irr;
    if (take) irr_nxt = irr_nxt & ~line_bit(p_idx);
    irr_nxt = irr_nxt | rise;
    if (init_clr) irr_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_req  <= '0;
      irr       <= '0;
      isr       <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      prev_req  <= irq_req;
      irr       <= irr_nxt;
      isr       <= isr_nxt;
      vec_valid <= int_ack;
      if (int_ack) vec_out <= line_vector(base, take ? p_idx : W'(N-1));
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N  = LINES,
  parameter int DW = BYTEW,
  localparam int W = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_port,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          secondary,
  input  logic [N-1:0]  irq_req,
  output logic          int_out,
  input  logic          int_ack,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid,
  output logic [N-1:0]  link_mask,
  output logic [2:0]    link_id,
  output logic          proc_mode
);
  logic          ready_w, init_clr_w, eoi_any_w, eoi_one_w;
  logic [W-1:0]  eoi_idx_w;
  logic [N-1:0]  mask_w, irr_w, isr_w;
  logic [DW-1:0] base_w;

  irqc_bus_regs #(.N(N), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .secondary(secondary), .ready(ready_w),
    .mask(mask_w), .base(base_w), .link_mask(link_mask), .link_id(link_id),
    .proc_mode(proc_mode), .init_clr(init_clr_w), .eoi_any(eoi_any_w),
    .eoi_one(eoi_one_w), .eoi_idx(eoi_idx_w)
  );

  irqc_core #(.N(N), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask(mask_w), .base(base_w),
    .ready(ready_w), .init_clr(init_clr_w), .eoi_any(eoi_any_w),
    .eoi_one(eoi_one_w), .eoi_idx(eoi_idx_w), .int_ack(int_ack),
    .irr(irr_w), .isr(isr_w), .int_out(int_out), .vec_out(vec_out),
    .vec_valid(vec_valid)
  );

  assign bus_rdata = bus_port ? DW'(mask_w) : DW'(isr_w);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         int_out,
  input logic         int_ack,
  input logic         vec_valid,
  input logic         ready,
  input logic         init_clr,
  input logic         eoi_any,
  input logic         eoi_one,
  input logic [W-1:0] eoi_idx,
  input logic [N-1:0] mask,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr
);
  a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  a_r4_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  a_r5_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !isr[0]);

  a_r3_vector_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> vec_valid);

  a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !eoi_any && !eoi_one && !init_clr)
      |=> ($countones(isr) == $past($countones(isr)) + 1));

  a_r10_idle_ack_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out && !eoi_any && !eoi_one && !init_clr)
      |=> (isr == $past(isr)));

  a_r7_any_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_any && (isr != '0) && !int_ack)
      |=> ($countones(isr) + 1 == $past($countones(isr))));

  a_r8_named_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_one && !int_ack) |=> !isr[$past(eoi_idx)]);

  a_r11_init_empties: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (isr == '0));
endmodule

bind prio_irq_ctrl irqc_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .int_ack(int_ack),
  .vec_valid(vec_valid), .ready(ready_w), .init_clr(init_clr_w),
  .eoi_any(eoi_any_w), .eoi_one(eoi_one_w), .eoi_idx(eoi_idx_w),
  .mask(mask_w), .irr(irr_w), .isr(isr_w)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_port = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       secondary = 1'b0;
  logic [7:0] irq_req = '0;
  logic       int_out, int_ack = 1'b0, vec_valid, proc_mode;
  logic [7:0] vec_out, link_mask;
  logic [2:0] link_id;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .secondary(secondary),
    .irq_req(irq_req), .int_out(int_out), .int_ack(int_ack),
    .vec_out(vec_out), .vec_valid(vec_valid), .link_mask(link_mask),
    .link_id(link_id), .proc_mode(proc_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_port = port; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_port(input logic port, output logic [7:0] d);
    @(negedge clk); bus_port = port; #1 d = bus_rdata;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_req = v;
    @(negedge clk);
  endtask

  // driver: pushes the expected vector, monitor pops it
  task automatic ack(input logic [7:0] expv);
    @(negedge clk); int_ack = 1'b1; exp_q.push_back(expv);
    @(negedge clk); int_ack = 1'b0;
  endtask

  always @(negedge clk) begin
    if (vec_valid) begin
      if (exp_q.size() == 0) chk("R3 unexpected vector", {24'h0, vec_out}, 32'hFFFF);
      else chk("R3 vector", {24'h0, vec_out}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_port(1'b1, rd); chk("R1 mask", rd, 8'hFF);
    rd_port(1'b0, rd); chk("R1 isr", rd, 8'h00);
    chk("R1 int_out", int_out, 0);
    wr(1'b1, 8'h00);
    // R2 / R11 initialization with fourth word, request during it
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40);
    lines(8'h08);
    chk("R11 quiet in init", int_out, 0);
    wr(1'b1, 8'h04);
    chk("R1 quiet before last word", int_out, 0);
    wr(1'b1, 8'h01);
    chk("R2 link_mask", link_mask, 8'h04);
    chk("R2 proc_mode", proc_mode, 1);
    chk("R1 int_out after init", int_out, 1);
    rd_port(1'b1, rd); chk("R2 mask kept", rd, 8'h00);
    // R3/R6/R9
    ack(8'h43);
    rd_port(1'b0, rd); chk("R6 isr", rd, 8'h08);
    chk("R9 held line no rerequest", int_out, 0);
    lines(8'h00);
    // R5 lower blocked, higher passes
    lines(8'h20);
    chk("R5 lower blocked", int_out, 0);
    lines(8'h22);
    chk("R5 higher passes", int_out, 1);
    ack(8'h41);
    rd_port(1'b0, rd); chk("R6 isr two", rd, 8'h0A);
    // R7
    wr(1'b0, 8'h20);
    rd_port(1'b0, rd); chk("R7 ns eoi", rd, 8'h08);
    chk("R5 still blocked", int_out, 0);
    // R8
    wr(1'b0, 8'h63);
    rd_port(1'b0, rd); chk("R8 specific", rd, 8'h00);
    chk("R5 released", int_out, 1);
    ack(8'h45);
    wr(1'b0, 8'h62);
    rd_port(1'b0, rd); chk("R8 other bit untouched", rd, 8'h20);
    wr(1'b0, 8'h65);
    rd_port(1'b0, rd); chk("R8 cleared", rd, 8'h00);
    lines(8'h00);
    // R4 masking
    wr(1'b1, 8'h01);
    lines(8'h41);
    ack(8'h46);
    rd_port(1'b1, rd); chk("R4 mask read", rd, 8'h01);
    rd_port(1'b0, rd); chk("R4 isr", rd, 8'h40);
    wr(1'b0, 8'h20);
    chk("R4 masked held", int_out, 0);
    wr(1'b1, 8'h00);
    chk("R4 unmask releases", int_out, 1);
    ack(8'h40);
    lines(8'h00);
    // R12
    wr(1'b0, 8'h05);
    rd_port(1'b0, rd); chk("R12 isr", rd, 8'h01);
    rd_port(1'b1, rd); chk("R12 mask", rd, 8'h00);
    wr(1'b0, 8'h20);
    // R10 spurious
    ack(8'h47);
    rd_port(1'b0, rd); chk("R10 isr", rd, 8'h00);
    // R3 several at once
    lines(8'h94);
    ack(8'h42);
    chk("R5 blocked by 2", int_out, 0);
    wr(1'b0, 8'h20);
    ack(8'h44);
    wr(1'b0, 8'h20);
    ack(8'h47);
    wr(1'b0, 8'h20);
    rd_port(1'b0, rd); chk("R7 all retired", rd, 8'h00);
    lines(8'h00);
    // R11 re-init as secondary without fourth word
    lines(8'h02);
    ack(8'h41);
    lines(8'h06);
    secondary = 1'b1;
    wr(1'b0, 8'h10);
    rd_port(1'b0, rd); chk("R11 isr cleared", rd, 8'h00);
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h05);
    chk("R2 link_id", link_id, 3'd5);
    chk("R2 link_mask secondary", link_mask, 8'h00);
    chk("R2 no fourth word", proc_mode, 0);
    wr(1'b1, 8'hF0);
    rd_port(1'b1, rd); chk("R2 mask after 3 words", rd, 8'hF0);
    chk("R11 pending cleared", int_out, 0);
    lines(8'h00);
    lines(8'h10);
    chk("R4 masked line", int_out, 0);
    lines(8'h14);
    chk("R3 request", int_out, 1);
    ack(8'h82);
    repeat (2) @(negedge clk);
    chk("R3 queue drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule